// File: doc/BRIEF.md
# Adder-Based ALU Slice with End-Around Rotator

This block is one slice of a narrow datapath. Two operands enter an arithmetic/logic unit built only from full-adder cells. A three-bit function code picks one of six operations: add, subtract, exclusive-or, exclusive-nor, and, or. The four logic operations do not use separate gates. Each cell's carry input is tied to a constant, and the slice keeps either the cell's sum output or its carry output.

On every rising clock edge the slice stores the result, together with a carry flag, in an output register. The stored value then passes through a combinational rotator and reaches the result bus. The rotator is controlled by one-hot lines, one line per rotation amount. A register file or bus master upstream supplies the operands and the control code in the same cycle.

Top module: `alu_rot_slice`

## Requirements
- R1: While rst_n is low, the stored result and carry_q are cleared. After reset with shift_oh = 0001, rot_out reads 0 and carry_q reads 0.
- R2: With op_sel = 000 (add), the next rising edge stores (opnd_a + opnd_b) mod 2^WIDTH, and carry_q takes the carry out of the top bit.
- R3: With op_sel = 001 (subtract), the slice stores (opnd_a - opnd_b) mod 2^WIDTH, computed as opnd_a plus the two's complement of opnd_b. carry_q is 1 exactly when opnd_a >= opnd_b as unsigned numbers.
- R4: With op_sel = 010, the slice stores opnd_a XOR opnd_b. With op_sel = 011, it stores opnd_a XNOR opnd_b. In both cases carry_q is 0.
- R5: With op_sel = 100, the slice stores opnd_a AND opnd_b. With op_sel = 101, it stores opnd_a OR opnd_b. In both cases carry_q is 0.
- R6: The codes op_sel = 110 and 111 are reserved. They store a zero result with carry_q = 0.
- R7: When only bit k of shift_oh is set, rot_out is the stored result rotated right by k places: rot_out[i] = stored[(i+k) mod WIDTH]. Bits that leave the low end come back in at the high end, and shift_err is 0.
- R8: When shift_oh has no bit set, or more than one bit set, rot_out is all zeros and shift_err is 1.
- R9: The rotator has no clock. A change on shift_oh alone changes rot_out within the same clock cycle, and the stored result is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 3 | Function code (see R2 to R6) |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| shift_oh | input | WIDTH | One-hot rotation select; bit k selects a right rotation by k places |
| rot_out | output | WIDTH | Rotated registered result |
| carry_q | output | 1 | Registered carry flag; 1 means no borrow when subtracting |
| shift_err | output | 1 | Set when shift_oh is not one-hot |

## Verification
Two things can happen in the same cycle: the register captures a new result, and a new rotation amount arrives on shift_oh. The bench changes both together on the falling edge. It then checks rot_out just after the rising edge against a behavioural model that rotates the newly expected value by the new amount. Another case also occurs in one cycle: a subtract that sets carry_q while shift_oh is invalid. That case must give shift_err high and a zero bus, while the carry flag still follows the subtraction.

// File: rtl/alu_rot_pkg.sv
package alu_rot_pkg;
   typedef enum logic [2:0] {
      OP_ADD  = 3'b000,
      OP_SUB  = 3'b001,
      OP_XOR  = 3'b010,
      OP_XNOR = 3'b011,
      OP_AND  = 3'b100,
      OP_OR   = 3'b101
   } alu_op_t;

   function automatic logic op_is_logic(input logic [2:0] code);
      return (code >= 3'b010) && (code <= 3'b101);
   endfunction
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   output logic s_o,
   output logic c_o
);
   logic half;
   assign half = a_i ^ b_i;
   assign s_o  = half ^ c_i;
   assign c_o  = (a_i & b_i) | (half & c_i);
endmodule

// File: rtl/adder_alu.sv
module adder_alu
   import alu_rot_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic [2:0]       op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] res_o,
   output logic             cout_o
);
   logic             is_arith;
   logic             is_sub;
   logic             force_c;
   logic             pick_carry;
   logic             valid_op;
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] sum_vec;
   logic [WIDTH-1:0] car_vec;
   logic             top_carry;

   always_comb begin
      is_arith   = 1'b0;
      is_sub     = 1'b0;
      force_c    = 1'b0;
      pick_carry = 1'b0;
      valid_op   = 1'b1;
      case (op_i)
         OP_ADD:  is_arith = 1'b1;
         OP_SUB:  begin is_arith = 1'b1; is_sub = 1'b1; end
         OP_XOR:  ;
         OP_XNOR: force_c = 1'b1;
         OP_AND:  pick_carry = 1'b1;
         OP_OR:   begin pick_carry = 1'b1; force_c = 1'b1; end
         default: valid_op = 1'b0;
      endcase
   end

   assign b_eff = is_sub ? ~b_i : b_i;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic ci_b;
      logic s_b;
      logic co_b;
      if (i == 0) begin : g_lsb
         assign ci_b = is_arith ? is_sub : force_c;
      end else begin : g_upper
         assign ci_b = is_arith ? g_bit[i-1].co_b : force_c;
      end
      fa_cell i_cell (
         .a_i (a_i[i]),
         .b_i (b_eff[i]),
         .c_i (ci_b),
         .s_o (s_b),
         .c_o (co_b)
      );
      assign sum_vec[i] = s_b;
      assign car_vec[i] = co_b;
   end

   assign top_carry = g_bit[WIDTH-1].co_b;

   always_comb begin
      if (!valid_op)       res_o = '0;
      else if (pick_carry) res_o = car_vec;
      else                 res_o = sum_vec;
      cout_o = is_arith & top_carry;
   end
endmodule

// File: rtl/onehot_rotator.sv
module onehot_rotator #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] din_i,
   input  logic [WIDTH-1:0] sel_i,
   output logic [WIDTH-1:0] dout_o,
   output logic             bad_o
);
   logic [WIDTH-1:0] term [WIDTH];

   for (genvar k = 0; k < WIDTH; k++) begin : g_amt
      if (k == 0) begin : g_pass
         assign term[k] = sel_i[k] ? din_i : '0;
      end else begin : g_rot
         assign term[k] = sel_i[k] ? ((din_i >> k) | (din_i << (WIDTH - k))) : '0;
      end
   end

   always_comb begin
      logic [WIDTH-1:0] acc;
      acc = '0;
      for (int k = 0; k < WIDTH; k++) acc |= term[k];
      bad_o  = !$onehot(sel_i);
      dout_o = bad_o ? '0 : acc;
   end
endmodule

// File: rtl/alu_rot_slice.sv
module alu_rot_slice
   import alu_rot_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       op_sel,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic [WIDTH-1:0] shift_oh,
   output logic [WIDTH-1:0] rot_out,
   output logic             carry_q,
   output logic             shift_err
);
   localparam int unsigned EXT_W = WIDTH + 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("alu_rot_slice: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] alu_res;
   logic             alu_cout;
   logic [WIDTH-1:0] result_q;

   adder_alu #(.WIDTH(WIDTH)) i_alu (
      .op_i   (op_sel),
      .a_i    (opnd_a),
      .b_i    (opnd_b),
      .res_o  (alu_res),
      .cout_o (alu_cout)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_q <= '0;
         carry_q  <= 1'b0;
      end else begin
         result_q <= alu_res;
         carry_q  <= alu_cout;
      end
   end

   onehot_rotator #(.WIDTH(WIDTH)) i_rot (
      .din_i  (result_q),
      .sel_i  (shift_oh),
      .dout_o (rot_out),
      .bad_o  (shift_err)
   );

   assert_add_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_ADD) |=> ({carry_q, result_q} ==
         (EXT_W'($past(opnd_a)) + EXT_W'($past(opnd_b)))));

   assert_sub_borrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_SUB) |=> (carry_q == ($past(opnd_a) >= $past(opnd_b))));

   assert_logic_no_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      op_is_logic(op_sel) |=> !carry_q);

   assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel[2:1] == 2'b11) |=> (result_q == '0) && !carry_q);

   assert_rot_keeps_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_err |-> ($countones(rot_out) == $countones(result_q)));

   assert_zero_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      shift_err |-> (rot_out == '0));
endmodule

// File: tb/test_alu_rot_slice.sv
module test_alu_rot_slice;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] op_sel = 3'b000;
   logic [3:0] opnd_a = 4'd0;
   logic [3:0] opnd_b = 4'd0;
   logic [3:0] shift_oh = 4'b0001;
   logic [3:0] rot_out;
   logic       carry_q;
   logic       shift_err;

   int vectors = 0;
   int miscompares = 0;
   int exp_res = 0;
   int exp_cy = 0;

   always #10 clk = ~clk;

   alu_rot_slice #(.WIDTH(4)) i_alu_rot_slice (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
      .opnd_b(opnd_b), .shift_oh(shift_oh), .rot_out(rot_out),
      .carry_q(carry_q), .shift_err(shift_err));

   function automatic int model_rot(input int r, input logic [3:0] sh);
      int amt;
      int ones;
      int outv;
      ones = 0;
      amt = 0;
      for (int k = 0; k < 4; k++) if (sh[k]) begin ones++; amt = k; end
      if (ones != 1) return 0;
      outv = 0;
      for (int i = 0; i < 4; i++)
         if ((r >> ((i + amt) % 4)) & 1) outv += (1 << i);
      return outv;
   endfunction

   task automatic model_alu(input int op, input int a, input int b);
      exp_cy = 0;
      case (op)
         0: begin exp_res = (a + b) % 16; exp_cy = (a + b) >= 16; end
         1: begin exp_res = (a - b + 16) % 16; exp_cy = (a >= b); end
         2: exp_res = a ^ b;
         3: exp_res = 15 - (a ^ b);
         4: exp_res = a & b;
         5: exp_res = a | b;
         default: exp_res = 0;
      endcase
   endtask

   task automatic compare(input string tag);
      int er;
      int ee;
      er = model_rot(exp_res, shift_oh);
      ee = ($countones(shift_oh) != 1);
      vectors++;
      if (int'(rot_out) != er || int'(carry_q) != exp_cy || int'(shift_err) != ee) begin
         miscompares++;
         $display("FAIL %s: rot_out=%0d carry=%0d err=%0d expected rot_out=%0d carry=%0d err=%0d",
                  tag, rot_out, carry_q, shift_err, er, exp_cy, ee);
      end
   endtask

   task automatic apply(input int op, input int a, input int b,
                        input logic [3:0] sh, input string tag);
      @(negedge clk);
      op_sel = 3'(op); opnd_a = 4'(a); opnd_b = 4'(b); shift_oh = sh;
      @(posedge clk);
      #1;
      model_alu(op, a, b);
      compare(tag);
   endtask

   initial begin
      #400000;
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      exp_res = 0; exp_cy = 0;
      compare("R1 reset state");
      @(negedge clk);
      rst_n = 1'b1;

      apply(0, 9, 8, 4'b0001, "R2 add with carry");
      apply(0, 3, 4, 4'b0001, "R2 add no carry");
      apply(1, 3, 5, 4'b0001, "R3 sub borrow");
      apply(1, 5, 5, 4'b0001, "R3 sub equal");
      apply(1, 12, 2, 4'b0001, "R3 sub positive");
      apply(2, 4'b1100, 4'b1010, 4'b0001, "R4 xor");
      apply(3, 4'b1100, 4'b1010, 4'b0001, "R4 xnor");
      apply(4, 4'b1100, 4'b1010, 4'b0001, "R5 and");
      apply(5, 4'b1100, 4'b1010, 4'b0001, "R5 or");
      apply(6, 15, 15, 4'b0001, "R6 reserved 110");
      apply(7, 9, 8, 4'b0001, "R6 reserved 111");
      apply(5, 4'b0001, 4'b0000, 4'b0010, "R7 rotate by 1");
      apply(5, 4'b0001, 4'b0000, 4'b0100, "R7 rotate by 2");
      apply(5, 4'b0011, 4'b0000, 4'b1000, "R7 rotate by 3");
      apply(1, 2, 1, 4'b0000, "R8 no shift line");
      apply(0, 9, 9, 4'b1100, "R8 two shift lines");

      // R9: move shift_oh inside the cycle, no clock edge in between
      apply(2, 4'b0110, 4'b0000, 4'b0001, "R9 setup");
      #3;
      shift_oh = 4'b0010;
      #2;
      compare("R9 rotate follows select mid-cycle");
      shift_oh = 4'b1000;
      #2;
      compare("R9 second mid-cycle change");

      for (int n = 0; n < 400; n++) begin
         logic [3:0] sh;
         if (($urandom % 4) == 0) sh = 4'($urandom);
         else sh = 4'(1 << ($urandom % 4));
         apply(int'($urandom % 8), int'($urandom % 16), int'($urandom % 16), sh,
               "R2-R8 random mix");
      end

      @(negedge clk);
      rst_n = 1'b0;
      shift_oh = 4'b0001;
      @(posedge clk);
      #1;
      exp_res = 0; exp_cy = 0;
      compare("R1 reset after traffic");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule